// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter whose configuration cannot be changed by a single stray write. Software opens a one-shot window by writing a first key to one register and a second key to another, in that order. The very next write to a guarded register (match value, enable control, or event status) is accepted, and the window then closes. Every further guarded write needs the full two-key sequence again. A wrong key value, keys out of order, or an ordinary write slipped in between the keys and the guarded write all close the window.

When counting is enabled, the counter advances once per clock. When it equals the programmed match value, the block latches an event flag. If reset generation is also enabled, it drives a reset pulse of fixed length. A counter-clear register restarts the count from zero without any unlock, which is how software services the watchdog. The current count can be read at any time.

Register word addresses (3-bit `addr`): 0 first key, 1 second key, 2 match value, 3 enable control, 4 event status, 5 counter clear, 6 count value. Reads are combinational and have no side effects.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the count, match value, enable control and event status all read 0, and `wdt_rst` is low.
- R2: Writing 0xBABA to address 0, then 0xEB10 to address 1, unlocks the block. The next write to address 2, 3 or 4 takes effect.
- R3: An unlock is consumed by exactly one guarded write. A second guarded write without a fresh key pair is ignored.
- R4: A wrong value at either key address, or a second key not directly preceded by a correct first key, leaves the block locked. A following guarded write is ignored.
- R5: A write to an unguarded address (5 or 6) between the second key and the guarded write cancels the unlock.
- R6: Enable control bit 0 set makes the count rise by exactly 1 each clock, wrapping at its width. With bit 0 clear the count holds.
- R7: With bit 0 set, a count equal to the match value sets event status bit 0 on the next clock.
- R8: A write to address 4 with bit 0 equal to 0 clears the event flag only when unlocked. A match in the same cycle wins.
- R9: If enable control bit 1 is also set, `wdt_rst` goes high on the clock after the match and stays high for exactly 8 cycles. With bit 1 clear it stays low.
- R10: Any write to address 5 sets the count to 0 on that clock, with no unlock needed, and takes precedence over counting.
- R11: Reading address 6 returns the current count. Addresses 2, 3 and 4 read back the match value, enable control and event status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
A lock state machine stuck open or advancing on a bad key shows up on the very next guarded write, as a changed readback of the match or control register. Loss of the window after the second key shows up the same way, as an unchanged readback. A counter or compare fault shifts the first cycle of `wdt_rst` away from match+1 clocks after enabling, so it is visible within the sweep window. A pulse-length fault appears within 9 cycles of the match. The sweep over many match values pins the exact edge of both the start and the end of the pulse.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_KEY1  = 3'd0,
        A_KEY2  = 3'd1,
        A_MATCH = 3'd2,
        A_CTRL  = 3'd3,
        A_STAT  = 3'd4,
        A_CLR   = 3'd5,
        A_COUNT = 3'd6
    } reg_addr_e;

    localparam logic [15:0] KEY_FIRST  = 16'hBABA;
    localparam logic [15:0] KEY_SECOND = 16'hEB10;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_HALF,
        LK_OPEN
    } lock_state_e;

    typedef struct packed {
        logic rst_en;
        logic cnt_en;
    } wdt_ctrl_t;

    function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
        case (a)
            A_MATCH, A_CTRL, A_STAT: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/kwdt_unlock.sv
module kwdt_unlock
    import kwdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              grant,
    output logic              unlocked
);
    lock_state_e state_q, state_d;

    logic first_ok, second_ok;
    assign first_ok  = (wdata == DATA_W'(KEY_FIRST));
    assign second_ok = (wdata == DATA_W'(KEY_SECOND));

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (addr)
                A_KEY1:  state_d = first_ok ? LK_HALF : LK_IDLE;
                A_KEY2:  state_d = (state_q == LK_HALF && second_ok) ? LK_OPEN : LK_IDLE;
                default: state_d = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_IDLE;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == LK_OPEN);
    assign grant    = wr_en && unlocked && is_guarded(addr);
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             clr,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (clr)    count <= '0;
        else if (cnt_en) count <= count + 1'b1;
    end

    assign hit = cnt_en && (count == match_val);
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse
);
    localparam int PW = $clog2(RST_CYC + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)              left_q <= '0;
        else if (trig)        left_q <= PW'(RST_CYC);
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int RST_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wdt_rst
);
    logic             grant, unlocked;
    logic [CNT_W-1:0] match_q, count_q;
    wdt_ctrl_t        ctrl_q;
    logic             status_q;
    logic             core_hit, clr_wr;

    kwdt_unlock #(.DATA_W(DATA_W)) u_lock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .grant(grant), .unlocked(unlocked)
    );

    assign clr_wr = wr_en && (addr == A_CLR);

    kwdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .cnt_en(ctrl_q.cnt_en), .clr(clr_wr),
        .match_val(match_q), .count(count_q), .hit(core_hit)
    );

    kwdt_pulse #(.RST_CYC(RST_CYC)) u_pulse (
        .clk(clk), .rst(rst), .trig(core_hit && ctrl_q.rst_en), .pulse(wdt_rst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q  <= '0;
            ctrl_q   <= '0;
            status_q <= 1'b0;
        end else begin
            if (grant && addr == A_MATCH) match_q <= wdata[CNT_W-1:0];
            if (grant && addr == A_CTRL)  ctrl_q  <= wdt_ctrl_t'(wdata[1:0]);
            if (core_hit)
                status_q <= 1'b1;
            else if (grant && addr == A_STAT && !wdata[0])
                status_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MATCH: rdata = DATA_W'(match_q);
            A_CTRL:  rdata = DATA_W'(ctrl_q);
            A_STAT:  rdata = DATA_W'(status_q);
            A_COUNT: rdata = DATA_W'(count_q);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
    import kwdt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RST_CYC = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] match_q,
    input logic             status_q,
    input logic             cnt_en,
    input logic             trig_in,
    input logic             hit_in,
    input logic             unlocked,
    input logic             wdt_rst
);
    localparam int SW = $clog2(RST_CYC + 2) + 1;

    logic [CNT_W-1:0] cnt_next;
    logic [SW-1:0]    since_q;
    logic             clr_now;

    assign cnt_next = count_q + 1'b1;
    assign clr_now  = wr_en && (addr == A_CLR);

    always_ff @(posedge clk) begin
        if (rst)                          since_q <= SW'(RST_CYC + 1);
        else if (trig_in)                 since_q <= SW'(1);
        else if (since_q <= SW'(RST_CYC)) since_q <= since_q + 1'b1;
    end

    // R2
    match_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(match_q) |-> $past(wr_en && addr == A_MATCH && unlocked));

    // R3
    unlock_spent_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_guarded(addr) && unlocked) |=> !unlocked);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !clr_now) |=> (count_q == $past(cnt_next)));

    // R10
    count_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_now |=> (count_q == '0));

    // R7
    status_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit_in |=> status_q);

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst == (since_q >= SW'(1) && since_q <= SW'(RST_CYC)));
endmodule

bind keyed_wdt kwdt_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .count_q(count_q), .match_q(match_q), .status_q(status_q),
    .cnt_en(ctrl_q.cnt_en), .trig_in(core_hit && ctrl_q.rst_en),
    .hit_in(core_hit), .unlocked(unlocked), .wdt_rst(wdt_rst)
);

// File: tb/keyed_wdt_test.sv
`timescale 1ns/100ps
module keyed_wdt_test;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [2:0]        addr = 3'd0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              wdt_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    keyed_wdt #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RST_CYC(8)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic open_lock();
        wr(3'd0, 32'hBABA);
        wr(3'd1, 32'hEB10);
    endtask

    task automatic guarded(input logic [2:0] a, input logic [31:0] d);
        open_lock();
        wr(a, d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, v2;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, v); check("R1 match", v, 0);
        rd(3'd3, v); check("R1 ctrl", v, 0);
        rd(3'd4, v); check("R1 status", v, 0);
        rd(3'd6, v); check("R1 count", v, 0);
        check("R1 wdt_rst", 32'(wdt_rst), 0);

        // R2 unlocked write works
        guarded(3'd2, 32'h11);
        rd(3'd2, v); check("R2 match write", v, 32'h11);
        // R3 second write without keys ignored
        wr(3'd2, 32'h22);
        rd(3'd2, v); check("R3 reuse ignored", v, 32'h11);
        // R4 wrong first key
        wr(3'd0, 32'hBABB); wr(3'd1, 32'hEB10); wr(3'd2, 32'h33);
        rd(3'd2, v); check("R4 bad key1", v, 32'h11);
        // R4 second key alone
        wr(3'd1, 32'hEB10); wr(3'd2, 32'h44);
        rd(3'd2, v); check("R4 key2 first", v, 32'h11);
        // R4 wrong second key
        wr(3'd0, 32'hBABA); wr(3'd1, 32'hEB11); wr(3'd3, 32'h3);
        rd(3'd3, v); check("R4 bad key2", v, 0);
        // R5 unguarded write cancels
        open_lock(); wr(3'd5, 32'h0); wr(3'd2, 32'h55);
        rd(3'd2, v); check("R5 cancel", v, 32'h11);
        // R2 after R4 failures a clean pair still works
        guarded(3'd2, 32'hF0);
        rd(3'd2, v); check("R2 relock ok", v, 32'hF0);

        // R6 stopped count holds
        rd(3'd6, v); @(negedge clk); rd(3'd6, v2);
        check("R6 hold", v2, v);

        // R11 control readback, R6 counting, R10 clear
        guarded(3'd2, 32'hF0);
        guarded(3'd3, 32'h1);
        rd(3'd3, v); check("R11 ctrl readback", v, 1);
        wr(3'd5, 32'h0);
        rd(3'd6, v); check("R10 clear", v, 0);
        bad = 0;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk); rd(3'd6, v);
            if (v !== 32'(k % 256)) bad++;
        end
        check("R6 step and wrap", 32'(bad), 0);
        rd(3'd4, v); check("R7 status after pass", v, 1);
        check("R9 no pulse when rst_en clear", 32'(wdt_rst), 0);

        // R8 clear status needs unlock
        guarded(3'd3, 32'h0);
        wr(3'd4, 32'h0);
        rd(3'd4, v); check("R8 locked clear ignored", v, 1);
        guarded(3'd4, 32'h0);
        rd(3'd4, v); check("R8 clear", v, 0);

        // R9 R7 sweep over match values
        for (int m = 0; m <= 40; m++) begin
            guarded(3'd4, 32'h0);
            guarded(3'd2, 32'(m));
            wr(3'd5, 32'h0);
            guarded(3'd3, 32'h3);
            bad = 0;
            for (int k = 1; k <= m + 12; k++) begin
                @(negedge clk);
                if (wdt_rst !== ((k >= m + 1) && (k <= m + 8))) bad++;
            end
            check($sformatf("R9 pulse timing m=%0d", m), 32'(bad), 0);
            rd(3'd4, v); check($sformatf("R7 status m=%0d", m), v, 1);
            guarded(3'd3, 32'h0);
        end

        // R9 rst_en clear: status only
        guarded(3'd4, 32'h0);
        guarded(3'd2, 32'h5);
        wr(3'd5, 32'h0);
        guarded(3'd3, 32'h1);
        bad = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (wdt_rst !== 1'b0) bad++;
        end
        check("R9 disabled pulse", 32'(bad), 0);
        rd(3'd4, v); check("R7 status no rst_en", v, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule